// File: doc/BRIEF.md
# Single-Bus Instruction Fetch Sequencer

This block fetches instructions over one shared internal bus. It runs a hardwired three-step control counter beside a small datapath. The datapath holds a program counter, a memory address register, a memory data register, an instruction register, a Z holding register and an ALU that can pass or increment its bus input.

In the first step the program counter is placed on the bus. The memory address register copies it, a read is requested, and the ALU's incremented result is caught in Z. In the second step Z drives the bus back into the program counter. The sequencer stays in this step until the memory signals completion, and at that point the returned word is taken into the data register. In the third step the data register drives the bus into the instruction register.

A one-cycle done pulse follows every fetch, and the sequence then starts again at once. Decoding and execution are left to surrounding logic.

Top module: `fetch_seq_top`

## Requirements
- R1: While reset is high, and in the cycle that follows, the step counter is in the first step, the program counter is zero, the instruction output is zero and the done pulse is low; so the first fetch after reset reads address 0.
- R2: The program counter and the memory address register capture from the bus on the falling clock edge. The address output therefore shows the program counter value from the middle of the first step and holds it through the wait step.
- R3: The read request is high in the first step and in every cycle of the wait step. It falls in the cycle after completion is seen, so it is high for exactly 2 + L cycles per fetch, where L is the number of wait cycles in which completion was low.
- R4: A fetch takes exactly 3 + L clock cycles. The first and third steps each last one cycle, and the wait step lasts L + 1 cycles.
- R5: The word present on the data input in the wait cycle where completion is high is captured into the data register. It then appears on the instruction output from the end of the third step.
- R6: Each fetch advances the program counter by exactly 1 through the ALU and Z. The counter wraps modulo 2^ADDR_W.
- R7: The done output is high for exactly one cycle, the cycle after the third step, and that cycle is already the first step of the next fetch.
- R8: At most one of the program counter, Z and the data register drives the internal bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Read address (memory address register) |
| mem_rd | output | 1 | Read request |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_mfc | input | 1 | Memory function complete |
| ir_q | output | DATA_W | Instruction register |
| fetch_done | output | 1 | One-cycle pulse after each completed fetch |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 8. A run of 24 fetches therefore passes the program counter through all 16 addresses and wraps it back past zero. Memory latency cycles through every value from 0 to 5 across consecutive fetches, so each stall length meets both a fresh address and a wrapped one. Every memory word is an arithmetic function of its address, which lets the bench predict the instruction, the address, the fetch length and the read-request length for each fetch.

// File: rtl/fetch_pkg.sv
`timescale 1ns/1ps
package fetch_pkg;

  typedef enum logic [1:0] {
    STEP_T1 = 2'd0,
    STEP_T2 = 2'd1,
    STEP_T3 = 2'd2
  } step_e;

  typedef enum logic {
    ALU_PASS = 1'b0,
    ALU_INC  = 1'b1
  } alu_fn_e;

  typedef struct packed {
    logic    pc_out;
    logic    z_out;
    logic    mdr_out;
    logic    pc_in;
    logic    mar_in;
    logic    z_in;
    logic    ir_in;
    logic    rd;
    logic    wmfc;
    alu_fn_e alu_fn;
  } ctl_t;

endpackage

// File: rtl/fetch_ctrl.sv
`timescale 1ns/1ps
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mfc,
  output ctl_t ctl,
  output logic done
);

  step_e step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= STEP_T1;
      done   <= 1'b0;
    end else begin
      done <= (step_q == STEP_T3);
      case (step_q)
        STEP_T1: step_q <= STEP_T2;
        STEP_T2: if (mfc) step_q <= STEP_T3;
        STEP_T3: step_q <= STEP_T1;
        default: step_q <= STEP_T1;
      endcase
    end
  end

  always_comb begin
    ctl        = '0;
    ctl.alu_fn = ALU_PASS;
    case (step_q)
      STEP_T1: begin
        ctl.pc_out = 1'b1;
        ctl.mar_in = 1'b1;
        ctl.rd     = 1'b1;
        ctl.z_in   = 1'b1;
        ctl.alu_fn = ALU_INC;
      end
      STEP_T2: begin
        ctl.z_out = 1'b1;
        ctl.pc_in = 1'b1;
        ctl.rd    = 1'b1;
        ctl.wmfc  = 1'b1;
      end
      STEP_T3: begin
        ctl.mdr_out = 1'b1;
        ctl.ir_in   = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  // R4
  t1_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q == STEP_T1) |=> (step_q == STEP_T2));

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q == STEP_T2 && !mfc) |=> (step_q == STEP_T2 && ctl.rd));

  // R7
  t3_done_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q == STEP_T3) |=> (done && step_q == STEP_T1));

endmodule

// File: rtl/fetch_datapath.sv
`timescale 1ns/1ps
module fetch_datapath
  import fetch_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic              mfc,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] ir_q
);

  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] z_q, mdr_q, bus, alu_y;

  always_comb begin
    bus = '0;
    if (ctl.pc_out)       bus = {{PAD_W{1'b0}}, pc_q};
    else if (ctl.z_out)   bus = z_q;
    else if (ctl.mdr_out) bus = mdr_q;
  end

  assign alu_y = (ctl.alu_fn == ALU_INC) ? bus + 1'b1 : bus;

  // PC and MAR sample the bus mid-cycle
  always_ff @(negedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
    end else begin
      if (ctl.pc_in)  pc_q  <= bus[ADDR_W-1:0];
      if (ctl.mar_in) mar_q <= bus[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      z_q   <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (ctl.z_in)          z_q   <= alu_y;
      if (ctl.wmfc && mfc)   mdr_q <= rdata;
      if (ctl.ir_in)         ir_q  <= bus;
    end
  end

  // R8
  bus_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.pc_out, ctl.z_out, ctl.mdr_out}));

  // R5
  ir_from_mdr_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.ir_in |=> (ir_q == $past(mdr_q)));

  // R6
  z_inc_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.z_in |=> (z_q[ADDR_W-1:0] == $past(pc_q) + 1'b1));

endmodule

// File: rtl/fetch_seq_top.sv
`timescale 1ns/1ps
module fetch_seq_top
  import fetch_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_mfc,
  output logic [DATA_W-1:0] ir_q,
  output logic              fetch_done
);

  ctl_t ctl;

  fetch_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .mfc  (mem_mfc),
    .ctl  (ctl),
    .done (fetch_done)
  );

  fetch_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ctl),
    .mfc   (mem_mfc),
    .rdata (mem_rdata),
    .mar_q (mem_addr),
    .ir_q  (ir_q)
  );

  assign mem_rd = ctl.rd;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_done |=> !fetch_done);

endmodule

// File: tb/fetch_seq_top_tb.sv
`timescale 1ns/1ps
module fetch_seq_top_tb_top;

  localparam int DW = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          mfc = 1'b0;
  logic [DW-1:0] rdata = '0;
  wire  [AW-1:0] addr;
  wire           rd;
  wire  [DW-1:0] ir;
  wire           done;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int cnt = 0;
  int rd_cycles = 0;
  logic [AW-1:0] addr_seen = '0;

  fetch_seq_top #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .mem_addr(addr), .mem_rd(rd),
    .mem_rdata(rdata), .mem_mfc(mfc), .ir_q(ir), .fetch_done(done)
  );

  function automatic logic [DW-1:0] word_at(input int a);
    return DW'((a * 37 + 5) & 8'hFF);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: completion after lat wait cycles
  always @(posedge clk) begin
    #1;
    if (rd) begin
      cnt = cnt + 1;
      rd_cycles = rd_cycles + 1;
    end else cnt = 0;
    if (cnt == 2) addr_seen = addr;
    mfc = rd && (cnt >= lat + 2);
    rdata = word_at(int'(addr));
  end

  initial begin
    #(200000 * 10);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #4;
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(ir == '0, "R1 ir in reset", int'(ir), 0);
    @(posedge clk);
    #2;
    rst = 1'b0;
    cnt = 1;
    rd_cycles = 1;
    lat = 0;
    #2;
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    for (int k = 0; k < 24; k++) begin
      n = 0;
      while (1) begin
        @(posedge clk);
        #4;
        n++;
        if (n == 1) check(done == 1'b0, "R7 done single cycle", int'(done), 0);
        if (done || n > 60) break;
      end
      check(n == 3 + lat, "R4 fetch cycles", n, 3 + lat);
      check(ir == word_at(k % 16), "R5/R8 ir content", int'(ir), int'(word_at(k % 16)));
      check(addr_seen == AW'(k % 16), "R2/R6/R1 fetch address", int'(addr_seen), k % 16);
      // the model already counted the next fetch's first step
      check(rd_cycles - 1 == 2 + lat, "R3 read request length", rd_cycles - 1, 2 + lat);
      rd_cycles = 1;
      lat = (k + 1) % 6;
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule